// File: doc/BRIEF.md
# DRAM Data Mask and Clock-Suspend Pipeline

This block sits on the device side of a synchronous DRAM data path and applies three controls with three different latencies while a burst runs. The data-mask pin hides read data two internal clocks after it is sampled. The same pin blocks a write beat in the very cycle it is sampled. The clock-enable pin freezes the internal clock one cycle after it is sampled, and a frozen clock stretches whatever burst is in flight.

The command logic starts a burst with a single pulse and a direction bit. The block then counts the beats of the burst, drives the array write strobe for write beats, and carries read data from the array through a short pipeline to the output driver together with a registered output enable. Masked beats still use up a burst position, so the count and the column order are never disturbed by masking. While the internal clock is frozen, the beat counter, the read pipeline and the output register all hold.

Top module: `dqp_io_pipe`

## Requirements
- R1: In reset and on the cycle after it, clk_en_o is 1 while busy_o, beat_o, wr_en_o and dq_oe_o are 0.
- R2: clk_en_o equals the value cke_i had one clock earlier, on entry to clock suspend and on exit from it alike.
- R3: A start accepted on an edge where clk_en_o is 1 gives exactly BURST_LEN beats on the following internal clocks, with beat_o counting 0 upward and busy_o high; after the last beat busy_o is 0 and beat_o is 0.
- R4: Data presented on rd_data_i during an unmasked read beat appears on dq_o with dq_oe_o at 1 two internal clocks later.
- R5: dqm_i at 1 during a read beat drives dq_oe_o to 0 two internal clocks later, and that beat still advances beat_o.
- R6: wr_en_o is 1 during a write beat when dqm_i is 0 and clk_en_o is 1, and 0 outside write beats.
- R7: dqm_i at 1 during a write beat forces wr_en_o to 0 in that same cycle, and the beat still advances beat_o.
- R8: While clk_en_o is 0, beat_o, busy_o, dq_o and dq_oe_o hold, wr_en_o is 0, and start_i and dqm_i have no effect.
- R9: A start accepted during a burst abandons it and begins a new burst at beat 0 with the new direction (wr_dir_i 1 is write, 0 is read).
- R10: dq_oe_o is 0 whenever no read beat took place two internal clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Clock-enable pin; low requests suspend |
| dqm_i | input | 1 | Data-mask pin |
| start_i | input | 1 | Burst start pulse from command logic |
| wr_dir_i | input | 1 | Direction at start: 1 write, 0 read |
| rd_data_i | input | DQ_W | Read data from the array for the current beat |
| clk_en_o | output | 1 | Internal clock enable |
| busy_o | output | 1 | A burst beat is in progress |
| beat_o | output | IDX_W | Beat index within the burst |
| wr_en_o | output | 1 | Array write strobe for the current beat |
| dq_o | output | DQ_W | Read data toward the output driver |
| dq_oe_o | output | 1 | Registered output enable for dq_o |

## Verification
The bench builds the block with BURST_LEN 4, DQ_W 8 and RD_LAT 2. A four-beat burst is short enough that one read and one write burst each contain a masked beat, a suspend cycle and the burst end, so the two mask latencies and the frozen clock can be seen acting on the same beats. The short burst also puts a restart in mid-burst and the end of the following burst within a few cycles.

// File: rtl/dqp_pkg.sv
package dqp_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Tag carried alongside each read beat through the output pipeline.
    typedef struct packed {
        logic valid;
        logic hide;
    } rd_tag_t;

    // Index width for a burst of a given length (never below one bit).
    function automatic int idx_width(input int len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/dqp_cke_gate.sv
module dqp_cke_gate (
    input  logic clk,
    input  logic rst,
    input  logic cke_i,
    output logic clk_en_o
);

    logic en_q;

    // One register between the pin and the internal enable gives the
    // single-clock latency both into and out of suspend.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b1;
        end else begin
            en_q <= cke_i;
        end
    end

    assign clk_en_o = en_q;

    // R2: enable lags the pin by exactly one clock
    p_cke_lag_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (clk_en_o == $past(cke_i)));

endmodule

// File: rtl/dqp_burst_seq.sv
module dqp_burst_seq
    import dqp_pkg::*;
#(
    parameter int BURST_LEN = 8,
    localparam int IDX_W    = idx_width(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en_i,
    input  logic             start_i,
    input  dir_e             dir_i,
    output logic             busy_o,
    output dir_e             dir_o,
    output logic [IDX_W-1:0] beat_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

    typedef struct packed {
        logic             active;
        dir_e             dir;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (clk_en_i) begin
            if (start_i) begin
                nxt.active = 1'b1;
                nxt.dir    = dir_i;
                nxt.idx    = '0;
            end else if (cur_q.active) begin
                if (cur_q.idx == LAST_IDX) begin
                    nxt.active = 1'b0;
                    nxt.idx    = '0;
                end else begin
                    nxt.idx = cur_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{active: 1'b0, dir: DIR_READ, idx: '0};
        end else begin
            cur_q <= nxt;
        end
    end

    assign busy_o = cur_q.active;
    assign dir_o  = cur_q.dir;
    assign beat_o = cur_q.idx;

    // R3: the beat index never leaves the burst
    p_beat_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (beat_o <= LAST_IDX));

    // R8: a frozen clock leaves the sequencer untouched
    p_seq_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en_i |=> ($stable(beat_o) && $stable(busy_o) && $stable(dir_o)));

    // R9: an accepted start always lands on beat 0 of a live burst
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (clk_en_i && start_i) |=> (busy_o && beat_o == '0));

endmodule

// File: rtl/dqp_read_pipe.sv
module dqp_read_pipe
    import dqp_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int RD_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clk_en_i,
    input  logic            beat_rd_i,
    input  logic            hide_i,
    input  logic [DQ_W-1:0] rd_data_i,
    output logic [DQ_W-1:0] dq_o,
    output logic            dq_oe_o
);

    // RD_LAT-1 tag/data stages, then a final register that holds the
    // enable itself so the pin sees a single flop output.
    localparam int STAGES = (RD_LAT > 1) ? RD_LAT - 1 : 1;

    rd_tag_t         tag_q [STAGES];
    logic [DQ_W-1:0] dat_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    tag_q[g] <= '0;
                    dat_q[g] <= '0;
                end else if (clk_en_i) begin
                    tag_q[g] <= '{valid: beat_rd_i, hide: hide_i};
                    dat_q[g] <= rd_data_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    tag_q[g] <= '0;
                    dat_q[g] <= '0;
                end else if (clk_en_i) begin
                    tag_q[g] <= tag_q[g-1];
                    dat_q[g] <= dat_q[g-1];
                end
            end
        end
    end

    logic            oe_q;
    logic [DQ_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            out_q <= '0;
        end else if (clk_en_i) begin
            oe_q  <= tag_q[STAGES-1].valid & ~tag_q[STAGES-1].hide;
            out_q <= dat_q[STAGES-1];
        end
    end

    assign dq_o    = out_q;
    assign dq_oe_o = oe_q;

    // R8: output side holds while the internal clock is frozen
    p_out_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en_i |=> ($stable(dq_oe_o) && $stable(dq_o)));

    // R10: enable can only rise on an edge where the clock ran
    p_oe_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe_o) |-> $past(clk_en_i));

endmodule

// File: rtl/dqp_io_pipe.sv
module dqp_io_pipe
    import dqp_pkg::*;
#(
    parameter int DQ_W      = 16,
    parameter int BURST_LEN = 8,
    parameter int RD_LAT    = 2,
    localparam int IDX_W    = idx_width(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_i,
    input  logic             dqm_i,
    input  logic             start_i,
    input  logic             wr_dir_i,
    input  logic [DQ_W-1:0]  rd_data_i,
    output logic             clk_en_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] beat_o,
    output logic             wr_en_o,
    output logic [DQ_W-1:0]  dq_o,
    output logic             dq_oe_o
);

    logic clk_en;
    logic busy;
    dir_e dir;
    logic rd_beat;
    logic wr_beat;

    dqp_cke_gate u_cke (
        .clk      (clk),
        .rst      (rst),
        .cke_i    (cke_i),
        .clk_en_o (clk_en)
    );

    dqp_burst_seq #(
        .BURST_LEN (BURST_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clk_en_i (clk_en),
        .start_i  (start_i),
        .dir_i    (wr_dir_i ? DIR_WRITE : DIR_READ),
        .busy_o   (busy),
        .dir_o    (dir),
        .beat_o   (beat_o)
    );

    assign rd_beat = busy && (dir == DIR_READ);
    assign wr_beat = busy && (dir == DIR_WRITE);

    dqp_read_pipe #(
        .DQ_W   (DQ_W),
        .RD_LAT (RD_LAT)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .clk_en_i  (clk_en),
        .beat_rd_i (rd_beat),
        .hide_i    (dqm_i),
        .rd_data_i (rd_data_i),
        .dq_o      (dq_o),
        .dq_oe_o   (dq_oe_o)
    );

    // Write mask acts in the cycle it is sampled: no register on the path.
    assign wr_en_o  = wr_beat && clk_en && !dqm_i;
    assign clk_en_o = clk_en;
    assign busy_o   = busy;

    // R6: strobe only during a write beat of a live burst
    p_wr_in_beat_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (busy_o && dir == DIR_WRITE));

    // R7: a sampled mask never lets a strobe through
    p_wr_mask_r7: assert property (@(posedge clk) disable iff (rst)
        dqm_i |-> !wr_en_o);

    // R8: no array write while frozen
    p_wr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en_o |-> !wr_en_o);

endmodule

// File: tb/dqp_io_pipe_test.sv
module dqp_io_pipe_test;

    localparam int DQ_W = 8;
    localparam int BL   = 4;
    localparam int IW   = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            cke_i, dqm_i, start_i, wr_dir_i;
    logic [DQ_W-1:0] rd_data_i;
    logic            clk_en_o, busy_o, wr_en_o, dq_oe_o;
    logic [IW-1:0]   beat_o;
    logic [DQ_W-1:0] dq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dqp_io_pipe #(.DQ_W(DQ_W), .BURST_LEN(BL), .RD_LAT(2)) uut (
        .clk(clk), .rst(rst), .cke_i(cke_i), .dqm_i(dqm_i),
        .start_i(start_i), .wr_dir_i(wr_dir_i), .rd_data_i(rd_data_i),
        .clk_en_o(clk_en_o), .busy_o(busy_o), .beat_o(beat_o),
        .wr_en_o(wr_en_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic d,
                         input logic c, input logic [7:0] r);
        @(negedge clk);
        start_i = s; wr_dir_i = w; dqm_i = d; cke_i = c; rd_data_i = r;
        #1;
    endtask

    // Per-cycle vector: {start,wr,dqm,cke}, rd_data,
    // expected {clk_en,busy,beat[1:0],wr_en,oe}, expected dq (checked when oe=1)
    localparam int NV = 15;
    localparam logic [25:0] VEC [NV] = '{
        {4'b1001, 8'h00, 6'b100000, 8'h00},  // read start
        {4'b0001, 8'h11, 6'b110000, 8'h00},  // beat0
        {4'b0011, 8'h22, 6'b110100, 8'h00},  // beat1 masked
        {4'b0000, 8'h33, 6'b111001, 8'h11},  // beat2, suspend req, beat0 out
        {4'b0011, 8'hFF, 6'b011100, 8'h00},  // frozen, dqm ignored
        {4'b0001, 8'h44, 6'b111100, 8'h00},  // beat3
        {4'b0001, 8'h00, 6'b100001, 8'h33},  // idle, beat2 out
        {4'b0001, 8'h00, 6'b100001, 8'h44},  // beat3 out
        {4'b1101, 8'h00, 6'b100000, 8'h00},  // write start
        {4'b0001, 8'h00, 6'b110010, 8'h00},  // wbeat0 strobe
        {4'b0011, 8'h00, 6'b110100, 8'h00},  // wbeat1 masked
        {4'b0000, 8'h00, 6'b111010, 8'h00},  // wbeat2, suspend req
        {4'b0001, 8'h00, 6'b011100, 8'h00},  // frozen
        {4'b0001, 8'h00, 6'b111110, 8'h00},  // wbeat3
        {4'b0001, 8'h00, 6'b100000, 8'h00}   // idle
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cke_i = 1'b0; dqm_i = 1'b1; start_i = 1'b1;
        wr_dir_i = 1'b1; rd_data_i = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state even with active inputs
        chk("R1 clk_en", clk_en_o, 1);
        chk("R1 busy", busy_o, 0);
        chk("R1 wr_en", wr_en_o, 0);
        chk("R1 oe", dq_oe_o, 0);
        drive(0, 0, 0, 1, 8'h00);
        rst = 1'b0;
        drive(0, 0, 0, 1, 8'h00);
        chk("R1 after clk_en", clk_en_o, 1);
        chk("R1 after beat", beat_o, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            drive(v[25], v[24], v[23], v[22], v[21:14]);
            chk("R2 clk_en", clk_en_o, v[13]);
            chk("R3 busy", busy_o, v[12]);
            chk("R3 beat", beat_o, v[11:10]);
            chk("R6/R7 wr_en", wr_en_o, v[9]);
            chk("R5/R10 oe", dq_oe_o, v[8]);
            if (v[8]) chk("R4 dq", dq_o, v[7:0]);
        end

        // R9: restart a read burst with a write in mid-burst
        drive(1, 0, 0, 1, 8'h00);
        drive(0, 0, 0, 1, 8'h00);
        drive(1, 1, 0, 1, 8'h00);
        chk("R9 read beat no strobe", wr_en_o, 0);
        drive(0, 0, 0, 1, 8'h00);
        chk("R9 beat", beat_o, 0);
        chk("R9 wr_en", wr_en_o, 1);
        drive(0, 0, 0, 1, 8'h00);
        drive(0, 0, 0, 1, 8'h00);
        drive(0, 0, 0, 1, 8'h00);
        chk("R3 last beat", beat_o, 3);
        drive(0, 0, 0, 1, 8'h00);
        chk("R3 end busy", busy_o, 0);

        // R8: start ignored while frozen
        drive(0, 0, 0, 0, 8'h00);
        drive(1, 0, 0, 1, 8'h00);
        chk("R8 frozen", clk_en_o, 0);
        drive(0, 0, 0, 1, 8'h00);
        chk("R8 start ignored", busy_o, 0);
        chk("R2 exit", clk_en_o, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule